// File: doc/BRIEF.md
# Random Generator Output and Alarm Register Block

This block is the register face of a hardware random number generator. A generator core hands it a 128-bit result with a one-cycle valid strobe. The block keeps that result in four 32-bit output words and sets a ready flag. While ready is set, every further result from the core is refused. Software reads the four words and then writes a one to the ready bit. Clearing ready tells the core, through `gen_req`, that it may deliver the next result.

Seven alarm pulses from the health-test logic each set a sticky status bit. A status bit is cleared only by writing a one to it. Each alarm bit has its own enable bit in the control register. When any enabled alarm bit is set, the single interrupt line goes high. The block also holds the generator's settings: the enable bit, the test-mode bit, the refill cycle limits and the alarm threshold. It drives these settings straight out to the core. A read-only register reports the hardware revision.

The register port has one write channel and one read channel. Reads return their data one cycle after the request.

Top module: `rng_csr`

## Requirements
- R1: After a synchronous reset, every readable register returns zero except the revision register. After reset `irq`, `gen_req` and `rd_data` are 0.
- R2: The output words are readable at byte offsets 0x00, 0x04, 0x08 and 0x0C. The word at offset 4*i returns bits [32*i+31:32*i] of the last accepted `gen_word`.
- R3: A `gen_valid` pulse is accepted only when ready (status bit 0) is clear and the enable bit (control bit 10) is set. Accepting a pulse loads the words and sets ready on the next edge. Any other pulse has no effect. `gen_req` equals enable AND NOT ready.
- R4: The status register is at 0x10. Bit 0 is ready. `alarm_evt[k]` sets status bit k+1: bit 1 is shutdown overflow, bit 2 stuck output, bit 3 noise, bit 4 run, bit 5 long run, bit 6 poker and bit 7 monobit.
- R5: Writing to 0x10 clears each status bit whose write-data bit is 1. It leaves each bit whose write-data bit is 0 unchanged.
- R6: If a set (an alarm pulse, or an accepted load for ready) and a clear of the same status bit arrive in the same cycle, the bit ends up set.
- R7: `irq` is registered. It is 1 in the cycle after any status bit 1..7 is set while the matching control bit 1..7 is also set. Ready never raises `irq`.
- R8: The control register is at 0x14 and keeps only bits 10, 8 and 7..1; all other bits read 0. The config register is at 0x18 and keeps bits 31:16 (maximum refill count) and 7:0 (minimum refill count). The threshold register is at 0x1C and keeps bits 7:0. These fields drive `cfg_*` from the next cycle.
- R9: The revision register at 0x7C reads {4'b0, major, minor, patch, 16'b0}, with fields of 4 bits each. Writes to it have no effect.
- R10: A read of any other offset returns 0. `rd_data` carries the pre-edge register value one cycle after `rd_en`, and it is 0 in every cycle that follows a cycle with `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| gen_word | input | NUM_WORDS*WORD_W | Result from the generator core |
| gen_valid | input | 1 | Result strobe |
| alarm_evt | input | 7 | Alarm pulses, bit k sets status bit k+1 |
| gen_req | output | 1 | Core may deliver a new result |
| irq | output | 1 | Interrupt |
| cfg_enable | output | 1 | Generator enable |
| cfg_test_mode | output | 1 | Test-mode select |
| cfg_max_refill | output | 16 | Maximum refill cycles |
| cfg_min_refill | output | 8 | Minimum refill cycles |
| cfg_alarm_thr | output | 8 | Alarm threshold |

## Verification
The main risk is the ready handshake. A ready bit stuck high shows at once as `gen_req` staying low. A load let through while ready is set shows on the next read of the output words, because they change value.

A lost alarm bit, or one cleared by a zero write, appears on the following status read. It also appears one cycle later as a wrong `irq` level. A stale or wrongly masked control value shows on the `cfg_*` pins in the cycle after the write. The reference model is compared against every output on every clock, so each such fault is caught within a cycle or two of the stimulus that exposes it.

// File: rtl/rng_csr_pkg.sv
package rng_csr_pkg;
  localparam int OFS_STAT  = 'h10;
  localparam int OFS_CTRL  = 'h14;
  localparam int OFS_CFG   = 'h18;
  localparam int OFS_THR   = 'h1C;
  localparam int OFS_REV   = 'h7C;
  localparam int N_ALARM   = 7;
  localparam int READY_BIT = 0;
  localparam int EN_BIT    = 10;
  localparam int TEST_BIT  = 8;
  localparam logic [31:0] CTRL_KEEP = 32'h0000_05FE;
  localparam logic [31:0] CFG_KEEP  = 32'hFFFF_00FF;

  typedef struct packed {
    logic        enable;
    logic        test_mode;
    logic [15:0] max_refill;
    logic [7:0]  min_refill;
    logic [7:0]  alarm_thr;
  } gen_cfg_t;
endpackage

// File: rtl/rng_out_words.sv
module rng_out_words #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic [NUM_WORDS*WORD_W-1:0]   din,
  output logic [NUM_WORDS*WORD_W-1:0]   words
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words[i*WORD_W +: WORD_W] <= '0;
      else if (load)
        words[i*WORD_W +: WORD_W] <= din[i*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/rng_status.sv
module rng_status #(
  parameter int N_ALARM = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_ready,
  input  logic               clr_wr,
  input  logic [N_ALARM:0]   clr_data,
  input  logic [N_ALARM-1:0] alarm_evt,
  output logic [N_ALARM:0]   stat
);
  logic [N_ALARM:0] clr_mask;
  logic [N_ALARM:0] set_mask;

  always_comb begin
    clr_mask = clr_wr ? clr_data : '0;
    set_mask = {alarm_evt, set_ready};
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (stat & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/rng_cfg_regs.sv
module rng_cfg_regs
  import rng_csr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       ctrl_q,
  output logic [31:0]       cfg_q,
  output logic [7:0]        thr_q
);
  logic hit_ctrl, hit_cfg, hit_thr;

  always_comb begin
    hit_ctrl = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
    hit_cfg  = wr_en && (wr_addr == ADDR_W'(OFS_CFG));
    hit_thr  = wr_en && (wr_addr == ADDR_W'(OFS_THR));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      thr_q  <= '0;
    end else begin
      if (hit_ctrl) ctrl_q <= wr_data & CTRL_KEEP;
      if (hit_cfg)  cfg_q  <= wr_data & CFG_KEEP;
      if (hit_thr)  thr_q  <= wr_data[7:0];
    end
  end
endmodule

// File: rtl/rng_csr.sv
module rng_csr
  import rng_csr_pkg::*;
#(
  parameter int          NUM_WORDS = 4,
  parameter int          WORD_W    = 32,
  parameter int          ADDR_W    = 7,
  parameter logic [3:0]  REV_MAJOR = 4'd2,
  parameter logic [3:0]  REV_MINOR = 4'd1,
  parameter logic [3:0]  REV_PATCH = 4'd3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [31:0]                 rd_data,
  input  logic [NUM_WORDS*WORD_W-1:0] gen_word,
  input  logic                        gen_valid,
  input  logic [6:0]                  alarm_evt,
  output logic                        gen_req,
  output logic                        irq,
  output logic                        cfg_enable,
  output logic                        cfg_test_mode,
  output logic [15:0]                 cfg_max_refill,
  output logic [7:0]                  cfg_min_refill,
  output logic [7:0]                  cfg_alarm_thr
);
  localparam int          WORD_BYTES = WORD_W / 8;
  localparam logic [31:0] REV_VALUE  = {4'b0, REV_MAJOR, REV_MINOR, REV_PATCH, 16'b0};

  logic [NUM_WORDS*WORD_W-1:0] words;
  logic [N_ALARM:0]            stat_q;
  logic [31:0]                 ctrl_q;
  logic [31:0]                 cfg_q;
  logic [7:0]                  thr_q;
  logic                        load;
  logic                        stat_wr;
  logic [31:0]                 rd_mux;
  gen_cfg_t                    gcfg;

  always_comb begin
    load    = gen_valid && !stat_q[READY_BIT] && ctrl_q[EN_BIT];
    stat_wr = wr_en && (wr_addr == ADDR_W'(OFS_STAT));
  end

  rng_out_words #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_words (
    .clk(clk), .rst(rst), .load(load), .din(gen_word), .words(words)
  );

  rng_status #(.N_ALARM(N_ALARM)) u_status (
    .clk(clk), .rst(rst), .set_ready(load), .clr_wr(stat_wr),
    .clr_data(wr_data[N_ALARM:0]), .alarm_evt(alarm_evt), .stat(stat_q)
  );

  rng_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .cfg_q(cfg_q), .thr_q(thr_q)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (rd_addr == ADDR_W'(i * WORD_BYTES))
        rd_mux = 32'(words[i*WORD_W +: WORD_W]);
    if (rd_addr == ADDR_W'(OFS_STAT)) rd_mux = 32'(stat_q);
    if (rd_addr == ADDR_W'(OFS_CTRL)) rd_mux = ctrl_q;
    if (rd_addr == ADDR_W'(OFS_CFG))  rd_mux = cfg_q;
    if (rd_addr == ADDR_W'(OFS_THR))  rd_mux = {24'b0, thr_q};
    if (rd_addr == ADDR_W'(OFS_REV))  rd_mux = REV_VALUE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= rd_en ? rd_mux : '0;
      irq     <= |(stat_q[N_ALARM:1] & ctrl_q[N_ALARM:1]);
    end
  end

  always_comb begin
    gcfg.enable     = ctrl_q[EN_BIT];
    gcfg.test_mode  = ctrl_q[TEST_BIT];
    gcfg.max_refill = cfg_q[31:16];
    gcfg.min_refill = cfg_q[7:0];
    gcfg.alarm_thr  = thr_q;
    gen_req         = gcfg.enable && !stat_q[READY_BIT];
    cfg_enable      = gcfg.enable;
    cfg_test_mode   = gcfg.test_mode;
    cfg_max_refill  = gcfg.max_refill;
    cfg_min_refill  = gcfg.min_refill;
    cfg_alarm_thr   = gcfg.alarm_thr;
  end
endmodule

// File: rtl/rng_csr_chk.sv
module rng_csr_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic [31:0]       rd_data,
  input logic              gen_valid,
  input logic [6:0]        alarm_evt,
  input logic [7:0]        stat,
  input logic [7:1]        ien,
  input logic              irq
);
  logic [7:0] clr_now;
  always_comb clr_now = (wr_en && wr_addr == ADDR_W'('h10)) ? wr_data[7:0] : 8'h00;

  // R3
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[0]) |-> $past(gen_valid));

  // R6
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (alarm_evt != 7'd0) |=> ((stat[7:1] & $past(alarm_evt)) == $past(alarm_evt)));

  // R5
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(stat) & ~stat & ~$past(clr_now)) == 8'h00));

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat[7:1] & ien) == 7'd0) |=> !irq);

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == 32'h0));
endmodule

bind rng_csr rng_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .gen_valid(gen_valid), .alarm_evt(alarm_evt),
  .stat(stat_q), .ien(ctrl_q[7:1]), .irq(irq)
);

// File: tb/rng_csr_tb.sv
`timescale 1ns/1ps
module rng_csr_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [6:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         rd_en = 1'b0;
  logic [6:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic [127:0] gen_word = '0;
  logic         gen_valid = 1'b0;
  logic [6:0]   alarm_evt = '0;
  logic         gen_req, irq, cfg_enable, cfg_test_mode;
  logic [15:0]  cfg_max_refill;
  logic [7:0]   cfg_min_refill, cfg_alarm_thr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [31:0] m_words [4];
  logic [7:0]  m_stat;
  logic [31:0] m_ctrl, m_cfg;
  logic [7:0]  m_thr;
  logic        m_irq;
  logic [31:0] m_rd;

  always #2 clk = ~clk;

  rng_csr u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .gen_word(gen_word),
    .gen_valid(gen_valid), .alarm_evt(alarm_evt), .gen_req(gen_req), .irq(irq),
    .cfg_enable(cfg_enable), .cfg_test_mode(cfg_test_mode),
    .cfg_max_refill(cfg_max_refill), .cfg_min_refill(cfg_min_refill),
    .cfg_alarm_thr(cfg_alarm_thr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(input logic [6:0] a);
    case (a)
      7'h00: return m_words[0];
      7'h04: return m_words[1];
      7'h08: return m_words[2];
      7'h0C: return m_words[3];
      7'h10: return {24'b0, m_stat};
      7'h14: return m_ctrl;
      7'h18: return m_cfg;
      7'h1C: return {24'b0, m_thr};
      7'h7C: return 32'h0213_0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare_all(input string tag);
    check({tag, " rd_data"}, rd_data, m_rd);
    check("R7 irq", {31'b0, irq}, {31'b0, m_irq});
    check("R3 gen_req", {31'b0, gen_req}, {31'b0, m_ctrl[10] & ~m_stat[0]});
    check("R8 cfg_enable", {31'b0, cfg_enable}, {31'b0, m_ctrl[10]});
    check("R8 cfg_test_mode", {31'b0, cfg_test_mode}, {31'b0, m_ctrl[8]});
    check("R8 cfg_max_refill", {16'b0, cfg_max_refill}, {16'b0, m_cfg[31:16]});
    check("R8 cfg_min_refill", {24'b0, cfg_min_refill}, {24'b0, m_cfg[7:0]});
    check("R8 cfg_alarm_thr", {24'b0, cfg_alarm_thr}, {24'b0, m_thr});
  endtask

  task automatic cyc(input logic we, input logic [6:0] wa, input logic [31:0] wd,
                     input logic re, input logic [6:0] ra, input logic gv,
                     input logic [127:0] gw, input logic [6:0] ev, input string tag);
    logic [7:0] ns;
    logic       ld;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    gen_valid = gv; gen_word = gw; alarm_evt = ev;
    @(posedge clk);
    m_rd  = re ? mread(ra) : 32'h0;
    m_irq = |(m_stat[7:1] & m_ctrl[7:1]);
    ld = gv && !m_stat[0] && m_ctrl[10];
    ns = m_stat;
    if (we && wa == 7'h10) ns = ns & ~wd[7:0];
    ns = ns | {ev, ld};
    if (ld) for (int i = 0; i < 4; i++) m_words[i] = gw[i*32 +: 32];
    m_stat = ns;
    if (we && wa == 7'h14) m_ctrl = wd & 32'h0000_05FE;
    if (we && wa == 7'h18) m_cfg  = wd & 32'hFFFF_00FF;
    if (we && wa == 7'h1C) m_thr  = wd[7:0];
    #1;
    compare_all(tag);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, a, d, 1'b0, 7'h0, 1'b0, '0, 7'h0, tag);
  endtask
  task automatic rd(input logic [6:0] a, input string tag);
    cyc(1'b0, 7'h0, 32'h0, 1'b1, a, 1'b0, '0, 7'h0, tag);
  endtask
  task automatic idle(input string tag);
    cyc(1'b0, 7'h0, 32'h0, 1'b0, 7'h0, 1'b0, '0, 7'h0, tag);
  endtask

  initial begin
    #(4ns * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] wa_word, wb_word;
    wa_word = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
    wb_word = 128'hDEAD_BEEF_CAFE_F00D_0123_4567_89AB_CDEF;
    for (int i = 0; i < 4; i++) m_words[i] = '0;
    m_stat = '0; m_ctrl = '0; m_cfg = '0; m_thr = '0; m_irq = 0; m_rd = '0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1 reset");
    rst = 1'b0;
    // R1: every register zero after reset, revision excepted (R9)
    foreach (m_words[i]) rd(7'(i * 4), "R1");
    rd(7'h10, "R1"); rd(7'h14, "R1"); rd(7'h18, "R1"); rd(7'h1C, "R1");
    rd(7'h7C, "R9");
    // R3: strobe ignored while disabled
    cyc(1'b0, 0, 0, 1'b0, 0, 1'b1, wa_word, 7'h0, "R3");
    rd(7'h10, "R3"); rd(7'h00, "R3");
    // R8: only kept control bits stored
    wr(7'h14, 32'hFFFF_FFFF, "R8"); rd(7'h14, "R8");
    wr(7'h14, 32'h0000_04FE, "R8"); rd(7'h14, "R8");
    // R2/R3: load, then strobe while ready is ignored
    cyc(1'b0, 0, 0, 1'b0, 0, 1'b1, wa_word, 7'h0, "R3");
    cyc(1'b0, 0, 0, 1'b1, 7'h10, 1'b1, wb_word, 7'h0, "R3");
    foreach (m_words[i]) rd(7'(i * 4), "R2");
    // R7: ready alone never raises irq
    idle("R7"); idle("R7");
    // R5: zero write leaves ready; one write clears it
    wr(7'h10, 32'h0000_0000, "R5"); rd(7'h10, "R5");
    wr(7'h10, 32'h0000_0001, "R5"); rd(7'h10, "R5");
    // R6: clear of ready together with an accepted load
    cyc(1'b1, 7'h10, 32'h1, 1'b0, 0, 1'b1, wb_word, 7'h0, "R6");
    rd(7'h10, "R6");
    foreach (m_words[i]) rd(7'(i * 4), "R2");
    // R4: each alarm pulse sets its own bit
    for (int k = 0; k < 7; k++) begin
      cyc(1'b0, 0, 0, 1'b0, 0, 1'b0, '0, 7'(1 << k), "R4");
      rd(7'h10, "R4");
    end
    idle("R7");
    // R5: clear some bits, keep the rest
    wr(7'h10, 32'h0000_00AA, "R5"); rd(7'h10, "R5");
    // R6: pulse and clear of same bit in one cycle
    cyc(1'b1, 7'h10, 32'h0000_00FE, 1'b0, 0, 1'b0, '0, 7'h04, "R6");
    rd(7'h10, "R6"); idle("R7");
    // R7: masking removes irq
    wr(7'h14, 32'h0000_0400, "R7"); idle("R7"); idle("R7");
    wr(7'h14, 32'h0000_0408, "R7"); idle("R7"); idle("R7");
    // R8: config and threshold
    wr(7'h18, 32'h1234_5678, "R8"); rd(7'h18, "R8");
    wr(7'h1C, 32'hFFFF_FFA5, "R8"); rd(7'h1C, "R8");
    wr(7'h14, 32'h0000_0500, "R8"); idle("R8");
    // R9: revision write ignored
    wr(7'h7C, 32'hFFFF_FFFF, "R9"); rd(7'h7C, "R9");
    // R10: unmapped offsets
    rd(7'h20, "R10"); rd(7'h02, "R10"); rd(7'h78, "R10"); rd(7'h40, "R10");
    // mixed stimulus
    for (int n = 0; n < 400; n++) begin
      logic [6:0] addrs [10];
      addrs = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h10, 7'h14, 7'h18, 7'h1C, 7'h7C, 7'h30};
      cyc(($urandom % 4) == 0, addrs[$urandom % 10],
          (($urandom % 2) == 0) ? 32'h0000_0001 : $urandom,
          ($urandom % 2) == 0, addrs[$urandom % 10],
          ($urandom % 3) == 0, {$urandom, $urandom, $urandom, $urandom},
          (($urandom % 5) == 0) ? 7'($urandom) : 7'h0, "R4 mixed");
    end
    idle("R10");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule